// File: doc/BRIEF.md
# Ethernet DMA Control and Status Register Bank

This block is the software-visible register file of an Ethernet DMA engine. A processor reaches it over a simple 32-bit register bus that uses word addresses, meaning the byte address shifted right by two. Through this bus it programs the bus mode, the receive and transmit descriptor ring bases, DMA control and interrupt enables. It reads back and clears status, and it can read the current descriptor pointers.

The ring engines sit beside the block. They raise status bits with single-cycle set pulses, and they advance the current descriptor pointers through a dedicated update port. In return they receive from the block the current pointers, the receive and transmit enable bits, and a one-cycle poll strobe that fires when software writes the transmit poll address. The block drives a single level-sensitive interrupt, which is high whenever an enabled status bit is set.

Frame data never passes through this block.

Top module: `dma_csr_bank`

## Requirements
- R1: After reset every stored register reads zero, `irq` is low, `tx_poll` is low, and `rx_en` and `tx_en` are low.
- R2: Writing word address 0x3C5 (status) clears each status bit whose written data bit is one. Bits written as zero keep their value.
- R3: A one on `sts_set[i]` sets status bit i at that clock edge. When a set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R4: Writing 0x3C3 (receive ring base) or 0x3C4 (transmit ring base) stores the value in that base register and in the matching current pointer. The receive pointer reads at 0x3D3 and the transmit pointer at 0x3D2. Both pointers are also driven on `rx_cur` and `tx_cur`.
- R5: A pulse on `rx_cur_wr` or `tx_cur_wr` loads the matching current pointer from the engine data and leaves the base unchanged. A software base write in the same cycle wins over the engine update.
- R6: `irq` is high exactly when some bit of status AND interrupt enable (0x3C7) is one. It follows from the register values present after the clock edge that updated them.
- R7: A write to 0x3C0 (bus mode) stores the data with bit 0 forced to zero.
- R8: A write to 0x3C1 stores nothing, so reading 0x3C1 returns zero. It produces `tx_poll` high for exactly the one cycle after the write edge.
- R9: Reading word address 0x008 always returns 0x1012, whatever was written there. Reads of addresses that hold no register return zero. Writes to such addresses have no effect.
- R10: Control register 0x3C6 stores the written value. Its bit 1 drives `rx_en` and its bit 13 drives `tx_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` (combinational) |
| sts_set | input | DW | Per-bit status set pulses from the engines |
| rx_cur_wr | input | 1 | Engine update of receive current pointer |
| rx_cur_din | input | DW | New receive current pointer |
| tx_cur_wr | input | 1 | Engine update of transmit current pointer |
| tx_cur_din | input | DW | New transmit current pointer |
| rx_cur | output | DW | Receive current descriptor pointer |
| tx_cur | output | DW | Transmit current descriptor pointer |
| rx_en | output | 1 | Receive enable (control bit 1) |
| tx_en | output | 1 | Transmit enable (control bit 13) |
| tx_poll | output | 1 | One-cycle transmit poll strobe |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check several behaviours on every cycle:
- A bit cleared by software stays cleared unless it was set in the same cycle.
- Every set pulse leaves its bit set.
- A base write leaves the base register and its current pointer equal.
- An engine update without a colliding base write lands in the pointer.
- The poll strobe follows only a poll write.
- Bus mode bit 0 is never one.
- The interrupt is never raised while status is empty.

The bench scenarios cover what the assertions cannot. These are the exact readback values at each address, the version constant, and the zero readback of unmapped and write-only addresses. They also include the outcome of a set and a clear colliding on the same bit, the enable masking of the interrupt, and the strobe's one-cycle width.

// File: rtl/dcsr_pkg.sv
package dcsr_pkg;
  localparam int unsigned ADDR_W = 10;

  // Word addresses
  localparam logic [ADDR_W-1:0] A_VERSION = 10'h008;
  localparam logic [ADDR_W-1:0] A_BUSMODE = 10'h3C0;
  localparam logic [ADDR_W-1:0] A_TXPOLL  = 10'h3C1;
  localparam logic [ADDR_W-1:0] A_RXBASE  = 10'h3C3;
  localparam logic [ADDR_W-1:0] A_TXBASE  = 10'h3C4;
  localparam logic [ADDR_W-1:0] A_STATUS  = 10'h3C5;
  localparam logic [ADDR_W-1:0] A_CTRL    = 10'h3C6;
  localparam logic [ADDR_W-1:0] A_IEN     = 10'h3C7;
  localparam logic [ADDR_W-1:0] A_TXCUR   = 10'h3D2;
  localparam logic [ADDR_W-1:0] A_RXCUR   = 10'h3D3;

  localparam logic [31:0] VERSION_VAL = 32'h0000_1012;
  localparam int unsigned CTRL_RXEN_BIT = 1;
  localparam int unsigned CTRL_TXEN_BIT = 13;

  // Ring index used by the pointer generate loop
  localparam int unsigned RING_RX = 0;
  localparam int unsigned RING_TX = 1;
  localparam int unsigned N_RINGS = 2;

  // Status update: clear by mask, then OR in set pulses (set wins)
  function automatic logic [31:0] w1c_next(input logic [31:0] q,
                                           input logic [31:0] clr,
                                           input logic [31:0] set);
    return (q & ~clr) | set;
  endfunction
endpackage

// File: rtl/dcsr_status.sv
module dcsr_status #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_en,
  input  logic [DW-1:0] clr_mask,
  input  logic [DW-1:0] set_mask,
  input  logic [DW-1:0] ien,
  output logic [DW-1:0] q,
  output logic          irq
);
  import dcsr_pkg::*;

  logic [DW-1:0] eff_clr;
  logic [DW-1:0] nxt;

  always_comb begin
    eff_clr = clr_en ? clr_mask : '0;
    nxt     = DW'(w1c_next(32'(q), 32'(eff_clr), 32'(set_mask)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  assign irq = |(q & ien);

  // R2: bits cleared by software and not set in the same cycle are zero afterwards
  a_r2_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((q & $past(clr_mask & ~set_mask)) == '0));

  // R3: every set pulse leaves its bit set
  a_r3_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask != '0) |=> ((q & $past(set_mask)) == $past(set_mask)));

  // R6: the interrupt never rises with empty status
  a_r6_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (q != '0));
endmodule

// File: rtl/dcsr_ptr.sv
module dcsr_ptr #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_wr,
  input  logic [DW-1:0] base_wdata,
  input  logic          eng_wr,
  input  logic [DW-1:0] eng_data,
  output logic [DW-1:0] base_q,
  output logic [DW-1:0] cur_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
    end else begin
      if (base_wr) base_q <= base_wdata;
      if (base_wr)     cur_q <= base_wdata;
      else if (eng_wr) cur_q <= eng_data;
    end
  end

  // R4: a base write reloads the current pointer
  a_r4_base_reload: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> (cur_q == $past(base_wdata)) && (base_q == $past(base_wdata)));

  // R5: an uncontested engine update lands in the pointer and leaves the base alone
  a_r5_engine_update: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_wr && !base_wr) |=> (cur_q == $past(eng_data)) && $stable(base_q));
endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] sts_set,
  input  logic          rx_cur_wr,
  input  logic [DW-1:0] rx_cur_din,
  input  logic          tx_cur_wr,
  input  logic [DW-1:0] tx_cur_din,
  output logic [DW-1:0] rx_cur,
  output logic [DW-1:0] tx_cur,
  output logic          rx_en,
  output logic          tx_en,
  output logic          tx_poll,
  output logic          irq
);
  import dcsr_pkg::*;

  localparam int unsigned NR = N_RINGS;

  // Decoded write events, named for the assertions
  logic wr_busmode, wr_poll, wr_status, wr_ctrl, wr_ien;
  logic [NR-1:0] wr_base;

  always_comb begin
    wr_busmode       = bus_wr && (bus_addr == AW'(A_BUSMODE));
    wr_poll          = bus_wr && (bus_addr == AW'(A_TXPOLL));
    wr_status        = bus_wr && (bus_addr == AW'(A_STATUS));
    wr_ctrl          = bus_wr && (bus_addr == AW'(A_CTRL));
    wr_ien           = bus_wr && (bus_addr == AW'(A_IEN));
    wr_base[RING_RX] = bus_wr && (bus_addr == AW'(A_RXBASE));
    wr_base[RING_TX] = bus_wr && (bus_addr == AW'(A_TXBASE));
  end

  logic [DW-1:0] busmode_q, ctrl_q, ien_q, status_q;
  logic          poll_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busmode_q <= '0;
      ctrl_q    <= '0;
      ien_q     <= '0;
      poll_q    <= 1'b0;
    end else begin
      if (wr_busmode) busmode_q <= bus_wdata & ~DW'(1);
      if (wr_ctrl)    ctrl_q    <= bus_wdata;
      if (wr_ien)     ien_q     <= bus_wdata;
      poll_q <= wr_poll;
    end
  end

  dcsr_status #(.DW(DW)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_en   (wr_status),
    .clr_mask (bus_wdata),
    .set_mask (sts_set),
    .ien      (ien_q),
    .q        (status_q),
    .irq      (irq)
  );

  // Ring pointer pairs: index 0 receive, index 1 transmit
  logic [DW-1:0] base_q [NR];
  logic [DW-1:0] cur_q  [NR];
  logic [NR-1:0] eng_wr;
  logic [DW-1:0] eng_din [NR];

  always_comb begin
    eng_wr[RING_RX]  = rx_cur_wr;
    eng_wr[RING_TX]  = tx_cur_wr;
    eng_din[RING_RX] = rx_cur_din;
    eng_din[RING_TX] = tx_cur_din;
  end

  for (genvar g = 0; g < NR; g++) begin : g_ring
    dcsr_ptr #(.DW(DW)) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .base_wr    (wr_base[g]),
      .base_wdata (bus_wdata),
      .eng_wr     (eng_wr[g]),
      .eng_data   (eng_din[g]),
      .base_q     (base_q[g]),
      .cur_q      (cur_q[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(A_VERSION): bus_rdata = DW'(VERSION_VAL);
      AW'(A_BUSMODE): bus_rdata = busmode_q;
      AW'(A_RXBASE):  bus_rdata = base_q[RING_RX];
      AW'(A_TXBASE):  bus_rdata = base_q[RING_TX];
      AW'(A_STATUS):  bus_rdata = status_q;
      AW'(A_CTRL):    bus_rdata = ctrl_q;
      AW'(A_IEN):     bus_rdata = ien_q;
      AW'(A_RXCUR):   bus_rdata = cur_q[RING_RX];
      AW'(A_TXCUR):   bus_rdata = cur_q[RING_TX];
      default:        bus_rdata = '0;
    endcase
  end

  assign rx_cur  = cur_q[RING_RX];
  assign tx_cur  = cur_q[RING_TX];
  assign rx_en   = ctrl_q[CTRL_RXEN_BIT];
  assign tx_en   = ctrl_q[CTRL_TXEN_BIT];
  assign tx_poll = poll_q;

  // R7: bus mode bit 0 never holds a one
  a_r7_busmode_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    busmode_q[0] == 1'b0);

  // R8: the strobe only follows a poll write
  a_r8_poll_origin: assert property (@(posedge clk) disable iff (!rst_n)
    tx_poll |-> $past(wr_poll));

  // R10: enables change only after a control write
  a_r10_enable_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(rx_en) && $stable(tx_en));
endmodule

// File: tb/dma_csr_bank_tb_top.sv
module dma_csr_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 10;
  localparam int NVEC = 9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic [DW-1:0] sts_set;
  logic          rx_cur_wr, tx_cur_wr;
  logic [DW-1:0] rx_cur_din, tx_cur_din;
  logic [DW-1:0] rx_cur, tx_cur;
  logic          rx_en, tx_en, tx_poll, irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_csr_bank #(.DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sts_set(sts_set),
    .rx_cur_wr(rx_cur_wr), .rx_cur_din(rx_cur_din),
    .tx_cur_wr(tx_cur_wr), .tx_cur_din(tx_cur_din),
    .rx_cur(rx_cur), .tx_cur(tx_cur), .rx_en(rx_en), .tx_en(tx_en),
    .tx_poll(tx_poll), .irq(irq)
  );

  // {write address, write data, expected readback at the same address}
  localparam logic [73:0] VEC [NVEC] = '{
    {10'h3C0, 32'hFFFF_FFFF, 32'hFFFF_FFFE},  // R7
    {10'h3C0, 32'h0000_0081, 32'h0000_0080},  // R7
    {10'h3C6, 32'h0000_2002, 32'h0000_2002},  // R10
    {10'h3C7, 32'h0000_0041, 32'h0000_0041},  // R6 enable setup
    {10'h3C3, 32'h0000_1000, 32'h0000_1000},  // R4
    {10'h3C4, 32'h0000_2000, 32'h0000_2000},  // R4
    {10'h3C1, 32'h0000_0005, 32'h0000_0000},  // R8
    {10'h008, 32'hDEAD_BEEF, 32'h0000_1012},  // R9
    {10'h155, 32'hCAFE_F00D, 32'h0000_0000}   // R9
  };

  function automatic string vec_req(input int i);
    case (i)
      0, 1:    return "R7";
      2:       return "R10";
      3:       return "R6";
      4, 5:    return "R4";
      6:       return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Write completes at the next posedge; returns at the following negedge
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse_set(input logic [DW-1:0] m);
    @(negedge clk);
    sts_set = m;
    @(negedge clk);
    sts_set = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] r;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    sts_set = '0; rx_cur_wr = 1'b0; tx_cur_wr = 1'b0;
    rx_cur_din = '0; tx_cur_din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(10'h3C5, r); check("R1", "status after reset", r, '0);
    rd(10'h3C0, r); check("R1", "bus mode after reset", r, '0);
    rd(10'h3D3, r); check("R1", "rx cur after reset", r, '0);
    check("R1", "irq/poll/en after reset", {28'd0, irq, tx_poll, rx_en, tx_en}, '0);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][73:64], VEC[i][63:32]);
      rd(VEC[i][73:64], r);
      check(vec_req(i), "vector readback", r, VEC[i][31:0]);
    end

    // R10 enables from control = 0x2002
    check("R10", "rx_en,tx_en", {30'd0, rx_en, tx_en}, 32'd3);
    // R4 current pointers after base writes
    rd(10'h3D3, r); check("R4", "rx cur reg", r, 32'h1000);
    rd(10'h3D2, r); check("R4", "tx cur reg", r, 32'h2000);
    check("R4", "tx_cur port", tx_cur, 32'h2000);

    // R3 and R6: enabled bit 6 raises irq
    check("R6", "irq idle", {31'd0, irq}, 0);
    pulse_set(32'h40);
    rd(10'h3C5, r); check("R3", "status after set", r, 32'h40);
    check("R6", "irq enabled bit", {31'd0, irq}, 1);
    // R2 clear
    wr(10'h3C5, 32'h40);
    rd(10'h3C5, r); check("R2", "status after w1c", r, 0);
    check("R6", "irq after clear", {31'd0, irq}, 0);
    // R6 masked bit
    pulse_set(32'h80);
    check("R6", "irq masked bit", {31'd0, irq}, 0);
    // R3 set beats clear; R2 clears bit 7
    @(negedge clk);
    sts_set = 32'h1; bus_wr = 1'b1; bus_addr = 10'h3C5; bus_wdata = 32'h81;
    @(negedge clk);
    sts_set = '0; bus_wr = 1'b0;
    rd(10'h3C5, r); check("R3", "set wins over clear", r, 32'h1);
    check("R6", "irq bit0 enabled", {31'd0, irq}, 1);
    // R2 zeros keep
    pulse_set(32'h40);
    wr(10'h3C5, 32'h1);
    rd(10'h3C5, r); check("R2", "zero bits keep", r, 32'h40);

    // R5 engine update
    @(negedge clk);
    tx_cur_wr = 1'b1; tx_cur_din = 32'h2020;
    @(negedge clk);
    tx_cur_wr = 1'b0;
    rd(10'h3D2, r); check("R5", "tx cur engine", r, 32'h2020);
    rd(10'h3C4, r); check("R5", "tx base unchanged", r, 32'h2000);
    // R5 collision: base write wins
    @(negedge clk);
    rx_cur_wr = 1'b1; rx_cur_din = 32'h5555;
    bus_wr = 1'b1; bus_addr = 10'h3C3; bus_wdata = 32'h3000;
    @(negedge clk);
    rx_cur_wr = 1'b0; bus_wr = 1'b0;
    check("R5", "rx cur collision", rx_cur, 32'h3000);

    // R8 poll strobe width
    wr(10'h3C1, 32'h1);
    check("R8", "poll high", {31'd0, tx_poll}, 1);
    @(negedge clk);
    check("R8", "poll low next", {31'd0, tx_poll}, 0);

    // R1 re-reset
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd(10'h3C5, r); check("R1", "status after re-reset", r, '0);
    check("R1", "irq after re-reset", {31'd0, irq}, 0);
    check("R1", "tx_cur after re-reset", tx_cur, '0);

    finish_run();
  end
endmodule